// File: doc/BRIEF.md
# Speaker Control and Refresh Status Port

This block is the byte-wide control and status port that sits beside an interval timer. A write sets two control bits. One drives the gate input of timer counter 2, and the other enables speaker data. The speaker output is counter 2's output passed through only while that enable is set.

A read returns one byte that mixes those two stored bits with live status. That status is the present level of counter 2's output and a slow, free-running refresh toggle. The toggle comes from a divider that counts system clock cycles, so it flips at a fixed interval of roughly 15 microseconds. With the default parameter and a 250 MHz clock that interval is 4096 cycles, or 2^14 ns. The block also ties the gate inputs of counters 0 and 1 high, which is their required state out of reset.

Two state machines carry the behaviour:
- Control machine. It has the states CTL_OFF, CTL_GATE, CTL_DATA and CTL_BOTH. On any write cycle it moves to the state that write bits 1:0 encode: 00 gives CTL_OFF, 01 gives CTL_GATE, 10 gives CTL_DATA and 11 gives CTL_BOTH. The move can go from any state to any state, and a write may also land on the state already held. Without a write, every state holds.
- Refresh machine. It has the states REF_LOW and REF_HIGH. It takes the transition TICK_RISE from REF_LOW to REF_HIGH, and the transition TICK_FALL from REF_HIGH to REF_LOW. Each transition fires when the divider reaches its terminal count.

Top module: `spkr_port`

## Requirements
- R1: A write (wr_en high at a clock edge) sets ch2_gate to wr_data bit 0 from that edge on.
- R2: A write sets the speaker data-enable to wr_data bit 1 from that edge on.
- R3: Read bit 0 shows ch2_gate and read bit 1 shows the data-enable, in the same cycle they change.
- R4: Read bit 5 equals the ch2_out input in the same cycle, with no register in between.
- R5: Read bit 4 is 0 after reset. It first inverts at the REF_HALF-th rising edge after reset release, and then inverts every REF_HALF rising edges.
- R6: Read bits 7, 6, 3 and 2 are always 0. Write bits 7 to 2 have no effect.
- R7: spk_out equals ch2_out AND the data-enable at all times.
- R8: During and after reset, ch2_gate and the data-enable are 0 and ch01_gate is 2'b11.
- R9: With wr_en low, ch2_gate and the data-enable keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write byte; bit 0 is the gate, bit 1 is the data-enable |
| ch2_out | input | 1 | Output level of timer counter 2 |
| ch2_gate | output | 1 | Gate drive for timer counter 2 |
| ch01_gate | output | 2 | Gate drives for counters 0 and 1, held high |
| spk_out | output | 1 | Gated speaker signal |
| rd_data | output | 8 | Status byte: bit 5 out, bit 4 refresh, bit 1 enable, bit 0 gate |

## Verification
- **Writes (R1, R2, R9).** The control bits change one rising edge after the write strobe. The bench therefore drives a write on a falling edge, drops the strobe on the next falling edge and samples there, which is one rising edge later.
- **Live paths (R3, R4, R7).** Read bit 5 and spk_out follow ch2_out in the same cycle. They are checked half a cycle after ch2_out changes, with no clock edge in between.
- **Refresh toggle (R5).** The toggle's first flip is due exactly REF_HALF rising edges after reset release. The bench releases reset on a falling edge, counts rising edges from there, and samples one edge before each expected flip and at the flip itself.

// File: rtl/spkr_port_pkg.sv
package spkr_port_pkg;

    // Read byte bit positions (decoded by software)
    localparam int RD_GATE_BIT    = 0;
    localparam int RD_EN_BIT      = 1;
    localparam int RD_REFRESH_BIT = 4;
    localparam int RD_OUT_BIT     = 5;

    // Write byte bit positions
    localparam int WR_GATE_BIT = 0;
    localparam int WR_EN_BIT   = 1;

    typedef enum logic [1:0] {
        CTL_OFF  = 2'b00,
        CTL_GATE = 2'b01,
        CTL_DATA = 2'b10,
        CTL_BOTH = 2'b11
    } ctl_state_t;

    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_t;

endpackage

// File: rtl/spkr_refresh_gen.sv
module spkr_refresh_gen
    import spkr_port_pkg::*;
#(
    parameter int REF_HALF = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic refresh
);

    localparam int CW = (REF_HALF > 2) ? $clog2(REF_HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(REF_HALF - 1);

    logic [CW-1:0] div_q;
    logic          tick;
    ref_state_t    state_q, state_d;

    assign tick = (div_q == TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Next-state: TICK_RISE and TICK_FALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_LOW:  if (tick) state_d = REF_HIGH;
            REF_HIGH: if (tick) state_d = REF_LOW;
            default:  state_d = REF_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REF_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            REF_HIGH: refresh = 1'b1;
            default:  refresh = 1'b0;
        endcase
    end

endmodule

// File: rtl/spkr_ctl_fsm.sv
module spkr_ctl_fsm
    import spkr_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       gate,
    output logic       data_en
);

    ctl_state_t state_q, state_d;
    logic       unused_hi;

    assign unused_hi = ^wr_data[7:2];

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case ({wr_data[WR_EN_BIT], wr_data[WR_GATE_BIT]})
                2'b00: state_d = CTL_OFF;
                2'b01: state_d = CTL_GATE;
                2'b10: state_d = CTL_DATA;
                2'b11: state_d = CTL_BOTH;
                default: state_d = CTL_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        gate    = 1'b0;
        data_en = 1'b0;
        unique case (state_q)
            CTL_OFF:  begin gate = 1'b0; data_en = 1'b0; end
            CTL_GATE: begin gate = 1'b1; data_en = 1'b0; end
            CTL_DATA: begin gate = 1'b0; data_en = 1'b1; end
            CTL_BOTH: begin gate = 1'b1; data_en = 1'b1; end
            default:  begin gate = 1'b0; data_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/spkr_rd_mux.sv
module spkr_rd_mux
    import spkr_port_pkg::*;
(
    input  logic       gate,
    input  logic       data_en,
    input  logic       refresh,
    input  logic       ch2_out,
    output logic [7:0] rd_data
);

    always_comb begin
        rd_data                 = '0;
        rd_data[RD_GATE_BIT]    = gate;
        rd_data[RD_EN_BIT]      = data_en;
        rd_data[RD_REFRESH_BIT] = refresh;
        rd_data[RD_OUT_BIT]     = ch2_out;
    end

endmodule

// File: rtl/spkr_port.sv
module spkr_port #(
    parameter int REF_HALF = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ch2_out,
    output logic       ch2_gate,
    output logic [1:0] ch01_gate,
    output logic       spk_out,
    output logic [7:0] rd_data
);

    logic data_en;
    logic refresh;

    spkr_ctl_fsm u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .gate    (ch2_gate),
        .data_en (data_en)
    );

    spkr_refresh_gen #(.REF_HALF(REF_HALF)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh)
    );

    spkr_rd_mux u_mux (
        .gate    (ch2_gate),
        .data_en (data_en),
        .refresh (refresh),
        .ch2_out (ch2_out),
        .rd_data (rd_data)
    );

    assign ch01_gate = 2'b11;
    assign spk_out   = ch2_out & data_en;

endmodule

// File: rtl/spkr_port_chk.sv
module spkr_port_chk #(
    parameter int REF_HALF = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ch2_out,
    input logic       ch2_gate,
    input logic       spk_out,
    input logic [7:0] rd_data
);

    localparam int KW = $clog2(REF_HALF + 1) + 1;

    logic [KW-1:0] since_flip;
    logic          ref_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_flip <= '0;
            ref_prev   <= 1'b0;
        end else begin
            ref_prev <= rd_data[4];
            if (rd_data[4] != ref_prev) since_flip <= KW'(1);
            else                        since_flip <= since_flip + 1'b1;
        end
    end

    AST_GATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ch2_gate == $past(wr_data[0]))); // R1
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[1] == $past(wr_data[1]))); // R2
    AST_GATE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == ch2_gate); // R3
    AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] == ch2_out); // R4
    AST_REFRESH_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] != ref_prev) |-> (since_flip == KW'(REF_HALF))); // R5
    AST_REFRESH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        since_flip <= KW'(REF_HALF)); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:6] == 2'b00) && (rd_data[3:2] == 2'b00)); // R6
    AST_SPK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        spk_out == (ch2_out & rd_data[1])); // R7
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ch2_gate) && $stable(rd_data[1]))); // R9

endmodule

bind spkr_port spkr_port_chk #(.REF_HALF(REF_HALF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ch2_out  (ch2_out),
    .ch2_gate (ch2_gate),
    .spk_out  (spk_out),
    .rd_data  (rd_data)
);

// File: tb/spkr_port_bench.sv
`timescale 1ns/1ps
module spkr_port_bench;

    localparam int HALF = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ch2_out = 1'b0;
    logic       ch2_gate;
    logic [1:0] ch01_gate;
    logic       spk_out;
    logic [7:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spkr_port #(.REF_HALF(HALF)) u_spkr_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ch2_out(ch2_out), .ch2_gate(ch2_gate), .ch01_gate(ch01_gate),
        .spk_out(spk_out), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = ~d;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 gate in reset", {7'd0, ch2_gate}, 8'h00);
        check("R8 ch01 gates", {6'd0, ch01_gate}, 8'h03);
        do_reset();
        check("R8 read after reset", rd_data & 8'hef, 8'h00);
    endtask

    task automatic t_writes();
        // bits 7:2 set in every pattern to show they are ignored
        for (int v = 0; v < 4; v++) begin
            ch2_out = 1'b0;
            do_write(8'hfc | 8'(v));
            check("R1 gate pin", {7'd0, ch2_gate}, {7'd0, 1'(v)});
            check("R2 R3 R6 read bits", rd_data & 8'hef, 8'(v));
        end
    endtask

    task automatic t_hold();
        do_write(8'h02);
        @(negedge clk);
        wr_data = 8'h01;
        repeat (5) @(negedge clk);
        check("R9 hold", rd_data & 8'hef, 8'h02);
    endtask

    task automatic t_live();
        do_write(8'h02);
        ch2_out = 1'b1;
        #1;
        check("R4 out bit", rd_data & 8'hef, 8'h22);
        check("R7 spk on", {7'd0, spk_out}, 8'h01);
        ch2_out = 1'b0;
        #1;
        check("R7 spk follows out", {7'd0, spk_out}, 8'h00);
        do_write(8'h01);
        ch2_out = 1'b1;
        #1;
        check("R7 spk blocked", {7'd0, spk_out}, 8'h00);
        check("R4 R3 out with gate", rd_data & 8'hef, 8'h21);
        ch2_out = 1'b0;
    endtask

    task automatic t_refresh();
        do_reset();  // released at a falling edge
        repeat (HALF - 1) @(negedge clk);
        check("R5 before first flip", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        check("R5 first flip", {7'd0, rd_data[4]}, 8'h01);
        repeat (HALF - 1) @(negedge clk);
        check("R5 before second flip", {7'd0, rd_data[4]}, 8'h01);
        @(negedge clk);
        check("R5 second flip", {7'd0, rd_data[4]}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_writes();
        t_hold();
        t_live();
        t_refresh();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule